// File: doc/BRIEF.md
# Monitor Channel Byte Transmitter

This block sends a message of several bytes through a monitor byte slot that recurs once per frame of a time-division serial link. Each byte travels with a one-bit handshake flag (MX) driven by this block, and the far end answers with its own acknowledge flag (MR). Both flags are active low: 0 means active and 1 means inactive. Everything on the frame side happens on a single-cycle frame strobe. On that strobe the block samples MR and updates the slot byte and MX.

The processor loads bytes into a holding register and uses a level-sensitive transmit-enable bit to start and end a message. A channel-busy status stays high from the start of a message until the closing idle frames have been sent. Two sticky flags report progress. The acknowledge flag means the far end has taken the current byte and the next byte may be loaded. The abort flag means the far end asked to stop. Each flag stays set until its own clear input is pulsed. The protocol has no timeout, so the processor may take any number of frames between handshake steps.

Top module: `mon_tx`

## Requirements
- R1: After reset, mx_o is 1, slot_o is all ones, busy_o is 0, and both ack_flag_o and abort_flag_o are 0.
- R2: If tx_en_i is 1 and a byte has been loaded, the next frame strobe puts that byte on slot_o, drives mx_o to 0 and sets busy_o to 1.
- R3: While a byte is waiting for acknowledge, a frame strobe with mr_i at 0 that follows a strobe with mr_i at 1 sets ack_flag_o. The flag stays 1 until ack_clr_i is pulsed.
- R4: If a new byte has been loaded after an acknowledge, the next strobe puts it on slot_o with mx_o at 1. At the strobe after that, mx_o returns to 0 and the byte is unchanged.
- R5: After an acknowledge, while no new byte is loaded and tx_en_i stays 1, each strobe repeats the same slot_o with mx_o at 0 and does not set ack_flag_o again.
- R6: Clearing tx_en_i makes the next strobe drive mx_o to 1 and slot_o to all ones. busy_o stays 1 through two such inactive frames and falls to 0 at the third strobe.
- R7: Once the first byte has been acknowledged, mr_i at 1 on two consecutive strobes sets abort_flag_o, forces mx_o to 1 and slot_o to all ones, and starts the closing sequence of R6.
- R8: Before the first acknowledge of a message, mr_i held at 1 for any number of strobes does not set abort_flag_o.
- R9: slot_o and mx_o change only on a clock edge where frame_stb_i is 1. With no strobe the state holds for any number of cycles, because there is no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe marking the monitor slot of each frame |
| tx_data_i | input | 8 | Byte written by the processor |
| tx_load_i | input | 1 | Write strobe for tx_data_i |
| tx_en_i | input | 1 | Transmit enable level |
| ack_clr_i | input | 1 | Clears ack_flag_o |
| abort_clr_i | input | 1 | Clears abort_flag_o |
| mr_i | input | 1 | Far-end acknowledge bit, active low |
| slot_o | output | 8 | Outgoing monitor slot byte |
| mx_o | output | 1 | Outgoing handshake bit, active low |
| busy_o | output | 1 | Channel active status |
| ack_flag_o | output | 1 | Sticky data-acknowledged flag |
| abort_flag_o | output | 1 | Sticky abort flag |

## Verification
Two situations are hard to reach from the ports. The first is an abort, which only counts after the first byte has been acknowledged. The second is a second acknowledge, which needs MR to go inactive for exactly one frame and then active again. The bench drives mr_i frame by frame to cover both. For the abort it first completes an acknowledge, then holds MR inactive for two strobes. For the second acknowledge it sends a single inactive frame after the gap frame. A separate run holds MR inactive for many strobes before any acknowledge, to show that this does not abort.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEND  = 3'd1,
    ST_ACKED = 3'd2,
    ST_GAP   = 3'd3,
    ST_END   = 3'd4
  } tx_state_e;
endpackage

// File: rtl/mon_tx_hold.sv
module mon_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '1;
      pending_o <= 1'b0;
    end else if (load_i) begin
      data_o    <= data_i;
      pending_o <= 1'b1;
    end else if (take_i) begin
      pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_tx_mr_watch.sv
module mon_tx_mr_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic mr_i,
  input  logic wait_ack_i,
  input  logic in_xfer_i,
  output logic ack_evt_o,
  output logic abort_evt_o
);
  logic mr_prev_q;
  logic mr_seen_q;

  // ack: MR goes active after an inactive frame
  assign ack_evt_o   = stb_i & wait_ack_i & mr_prev_q & ~mr_i;
  // abort: two inactive MR frames once the far end has answered
  assign abort_evt_o = stb_i & in_xfer_i & mr_seen_q & mr_prev_q & mr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr_prev_q <= 1'b1;
      mr_seen_q <= 1'b0;
    end else begin
      if (stb_i) mr_prev_q <= mr_i;
      if (!in_xfer_i)     mr_seen_q <= 1'b0;
      else if (ack_evt_o) mr_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mon_tx_fsm.sv
module mon_tx_fsm
  import mon_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned END_FRAMES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              en_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_evt_i,
  input  logic              abort_evt_i,
  output logic              take_o,
  output tx_state_e         state_o,
  output logic [DATA_W-1:0] slot_o,
  output logic              mx_o
);
  localparam int unsigned CNT_W = (END_FRAMES > 1) ? $clog2(END_FRAMES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(END_FRAMES - 1);
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  logic [CNT_W-1:0] end_cnt_q;
  logic             stop;

  assign stop   = abort_evt_i | ~en_i;
  assign take_o = stb_i & en_i & pending_i & ~abort_evt_i &
                  ((state_o == ST_IDLE) | (state_o == ST_ACKED));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_IDLE;
      slot_o    <= IDLE_BYTE;
      mx_o      <= 1'b1;
      end_cnt_q <= '0;
    end else if (stb_i) begin
      unique case (state_o)
        ST_IDLE: begin
          if (en_i && pending_i) begin
            slot_o  <= data_i;
            mx_o    <= 1'b0;
            state_o <= ST_SEND;
          end
        end
        ST_SEND, ST_ACKED, ST_GAP: begin
          if (stop) begin
            slot_o    <= IDLE_BYTE;
            mx_o      <= 1'b1;
            end_cnt_q <= '0;
            state_o   <= ST_END;
          end else if (state_o == ST_SEND) begin
            if (ack_evt_i) state_o <= ST_ACKED;
          end else if (state_o == ST_ACKED) begin
            if (pending_i) begin
              // new byte: one inactive MX frame marks it
              slot_o  <= data_i;
              mx_o    <= 1'b1;
              state_o <= ST_GAP;
            end
          end else begin
            mx_o    <= 1'b0;
            state_o <= ST_SEND;
          end
        end
        ST_END: begin
          slot_o <= IDLE_BYTE;
          mx_o   <= 1'b1;
          if (end_cnt_q == CNT_LAST) state_o <= ST_IDLE;
          else end_cnt_q <= end_cnt_q + 1'b1;
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mon_tx.sv
module mon_tx
  import mon_tx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned END_FRAMES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_stb_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              tx_en_i,
  input  logic              ack_clr_i,
  input  logic              abort_clr_i,
  input  logic              mr_i,
  output logic [DATA_W-1:0] slot_o,
  output logic              mx_o,
  output logic              busy_o,
  output logic              ack_flag_o,
  output logic              abort_flag_o
);
  logic [DATA_W-1:0] hold_data;
  logic              pending;
  logic              take;
  logic              ack_evt;
  logic              abort_evt;
  tx_state_e         state;
  logic              wait_ack;
  logic              in_xfer;

  assign wait_ack = (state == ST_SEND);
  assign in_xfer  = (state == ST_SEND) | (state == ST_ACKED) | (state == ST_GAP);
  assign busy_o   = (state != ST_IDLE);

  mon_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_load_i),
    .data_i    (tx_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .pending_o (pending)
  );

  mon_tx_mr_watch u_mr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (frame_stb_i),
    .mr_i        (mr_i),
    .wait_ack_i  (wait_ack),
    .in_xfer_i   (in_xfer),
    .ack_evt_o   (ack_evt),
    .abort_evt_o (abort_evt)
  );

  mon_tx_fsm #(.DATA_W(DATA_W), .END_FRAMES(END_FRAMES)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stb_i       (frame_stb_i),
    .en_i        (tx_en_i),
    .pending_i   (pending),
    .data_i      (hold_data),
    .ack_evt_i   (ack_evt),
    .abort_evt_i (abort_evt),
    .take_o      (take),
    .state_o     (state),
    .slot_o      (slot_o),
    .mx_o        (mx_o)
  );

  // sticky flags, set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_flag_o   <= 1'b0;
      abort_flag_o <= 1'b0;
    end else begin
      if (ack_evt)        ack_flag_o <= 1'b1;
      else if (ack_clr_i) ack_flag_o <= 1'b0;
      if (abort_evt)        abort_flag_o <= 1'b1;
      else if (abort_clr_i) abort_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_tx_chk.sv
module mon_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_stb_i,
  input logic              mr_i,
  input logic [DATA_W-1:0] slot_o,
  input logic              mx_o,
  input logic              busy_o,
  input logic              ack_flag_o,
  input logic              abort_flag_o
);
  p_idle_outputs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (mx_o && slot_o == '1));

  p_ack_on_mr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_flag_o) |-> ($past(frame_stb_i) && !$past(mr_i)));

  p_end_inactive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(mx_o));

  p_abort_mx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_flag_o) |-> (mx_o && $past(frame_stb_i) && $past(mr_i)));

  p_hold_no_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> ($stable(mx_o) && $stable(slot_o)));
endmodule

bind mon_tx mon_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_stb_i  (frame_stb_i),
  .mr_i         (mr_i),
  .slot_o       (slot_o),
  .mx_o         (mx_o),
  .busy_o       (busy_o),
  .ack_flag_o   (ack_flag_o),
  .abort_flag_o (abort_flag_o)
);

// File: tb/mon_tx_test.sv
module mon_tx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_stb_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_load_i = 1'b0;
  logic       tx_en_i = 1'b0;
  logic       ack_clr_i = 1'b0;
  logic       abort_clr_i = 1'b0;
  logic       mr_i = 1'b1;
  logic [7:0] slot_o;
  logic       mx_o, busy_o, ack_flag_o, abort_flag_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mon_tx uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_stb_i(frame_stb_i),
    .tx_data_i(tx_data_i), .tx_load_i(tx_load_i), .tx_en_i(tx_en_i),
    .ack_clr_i(ack_clr_i), .abort_clr_i(abort_clr_i), .mr_i(mr_i),
    .slot_o(slot_o), .mx_o(mx_o), .busy_o(busy_o),
    .ack_flag_o(ack_flag_o), .abort_flag_o(abort_flag_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic out_chk(input string req, input int slot, input int mx, input int busy);
    chk(req, "slot", slot_o, slot);
    chk(req, "mx", mx_o, mx);
    chk(req, "busy", busy_o, busy);
  endtask

  // one frame: strobe for one cycle, sample at the following falling edge
  task automatic frame(input logic mr);
    @(negedge clk_i);
    mr_i = mr;
    frame_stb_i = 1'b1;
    @(negedge clk_i);
    frame_stb_i = 1'b0;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk_i);
    tx_data_i = d;
    tx_load_i = 1'b1;
    @(negedge clk_i);
    tx_load_i = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk_i);
    ack_clr_i = 1'b1;
    abort_clr_i = 1'b1;
    @(negedge clk_i);
    ack_clr_i = 1'b0;
    abort_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    out_chk("R1", 8'hff, 1, 0);
    chk("R1", "ack_flag", ack_flag_o, 0);
    chk("R1", "abort_flag", abort_flag_o, 0);
  endtask

  task automatic t_message();
    load(8'ha5);
    tx_en_i = 1'b1;
    frame(1'b1);
    out_chk("R2", 8'ha5, 0, 1);
    for (int i = 0; i < 4; i++) frame(1'b1);
    chk("R8", "abort_flag", abort_flag_o, 0);
    chk("R8", "ack_flag early", ack_flag_o, 0);
    out_chk("R8", 8'ha5, 0, 1);
    frame(1'b0);
    chk("R3", "ack_flag", ack_flag_o, 1);
    repeat (5) @(negedge clk_i);
    chk("R3", "ack_flag sticky", ack_flag_o, 1);
    clr_flags();
    chk("R3", "ack_flag cleared", ack_flag_o, 0);
    frame(1'b0);
    frame(1'b0);
    out_chk("R5", 8'ha5, 0, 1);
    chk("R5", "no re-ack", ack_flag_o, 0);
    repeat (300) @(negedge clk_i);
    out_chk("R9", 8'ha5, 0, 1);
    load(8'h3c);
    out_chk("R9", 8'ha5, 0, 1);
    frame(1'b0);
    out_chk("R4", 8'h3c, 1, 1);
    frame(1'b0);
    out_chk("R4", 8'h3c, 0, 1);
    frame(1'b1);
    chk("R3", "no ack on inactive", ack_flag_o, 0);
    chk("R7", "one inactive no abort", abort_flag_o, 0);
    frame(1'b0);
    chk("R3", "second ack", ack_flag_o, 1);
    clr_flags();
    tx_en_i = 1'b0;
    frame(1'b0);
    out_chk("R6", 8'hff, 1, 1);
    frame(1'b1);
    out_chk("R6", 8'hff, 1, 1);
    frame(1'b1);
    out_chk("R6", 8'hff, 1, 0);
    chk("R6", "abort_flag", abort_flag_o, 0);
  endtask

  task automatic t_abort();
    load(8'h11);
    tx_en_i = 1'b1;
    frame(1'b1);
    out_chk("R2", 8'h11, 0, 1);
    frame(1'b0);
    chk("R3", "ack_flag", ack_flag_o, 1);
    frame(1'b1);
    chk("R7", "first inactive", abort_flag_o, 0);
    frame(1'b1);
    chk("R7", "abort_flag", abort_flag_o, 1);
    out_chk("R7", 8'hff, 1, 1);
    frame(1'b1);
    frame(1'b1);
    out_chk("R7", 8'hff, 1, 0);
    clr_flags();
    chk("R7", "abort cleared", abort_flag_o, 0);
    frame(1'b1);
    out_chk("R7", 8'hff, 1, 0);
    tx_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_message();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule